// File: doc/BRIEF.md
# Phase-Shifted LFSR Pattern Source

This block is a pseudo-random stimulus source for a self-test arrangement in which several scan chains are loaded at the same time. A four-stage shift register with external feedback runs through its fifteen nonzero states. A small XOR network turns the register into five channel bits, one per scan chain. Each channel carries the same fifteen-bit maximal-length sequence, but at a fixed offset from its neighbours. Adjacent chains therefore never receive copies of one another that are shifted by a single bit. The XOR taps are fixed. Each tap set was chosen so that its channel leads stage x1 by a known number of clock cycles.

The register steps only while the enable input is high. A load input replaces the register contents with a seed. A zero seed is not allowed, and the block substitutes 4'b0001 for it. The update of the register is chosen by a three-way action selector with the actions ACT_LOAD, ACT_STEP and ACT_HOLD. ACT_LOAD is taken when `load` is high. ACT_STEP is taken when `en` is high and `load` is low. ACT_HOLD is taken when both inputs are low. The register is the only storage in the block, and the channel bits are decoded from it combinationally.

Top module: `lfsr_phase_tpg`

## Requirements
- R1: While `rst_n` is low, `state` is 4'b0001. Bit 0 is stage x1 and bit 3 is stage x4.
- R2: On a rising clock edge with `en` high and `load` low, the next `state` is {x1^x2, x4, x3, x2}. The stream s(t)=x1 then obeys s(t+4)=s(t)^s(t+1), which is the polynomial x^4+x+1.
- R3: On a rising clock edge with `en` low and `load` low, `state` and `chan` do not change.
- R4: On a rising clock edge with `load` high, `state` becomes `seed`, whatever the value of `en`. A zero `seed` loads 4'b0001 instead.
- R5: `state` is never 4'b0000.
- R6: Starting from any state, 15 consecutive steps return `state` to its starting value, after visiting 15 distinct nonzero states.
- R7: `chan[0]` (channel 1) equals x1 of the current state, which is phase 0. All channel bits follow the current `state` in the same cycle.
- R8: `chan[2]` (channel 3) equals the x1 stream 4 steps ahead.
- R9: `chan[1]` (channel 2) equals the x1 stream 6 steps ahead.
- R10: `chan[3]` (channel 4) equals the x1 stream 12 steps ahead, which is 3 steps behind modulo 15.
- R11: `chan[4]` (channel 5) equals the x1 stream 7 steps ahead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the default seed |
| en | input | 1 | Advance the register by one step |
| load | input | 1 | Load `seed`; takes priority over `en` |
| seed | input | 4 | Seed value; zero is replaced by 4'b0001 |
| chan | output | 5 | Channel bits; bit k-1 is channel k |
| state | output | 4 | Raw register, {x4, x3, x2, x1} |

## Verification
A wrong feedback tap or a wrong shift shows up on `state` at the next enabled edge. It also appears on the channel bits at the same sample, because the channels are decoded without delay. A wrong XOR tap in the network gives a channel that is not a time-shifted copy of channel 1. The bench holds a look-ahead copy of the sequence and compares every channel against it after every clock. A mismatch is therefore reported within the first few steps after reset or after a seed load. A stuck or zero register is caught by the period check and by the nonzero check.

// File: rtl/lfsr_ps_pkg.sv
package lfsr_ps_pkg;
    localparam int LFSR_W     = 4;
    localparam int NUM_CH     = 5;
    localparam int SEQ_PERIOD = (1 << LFSR_W) - 1;

    typedef logic [LFSR_W-1:0] lfsr_state_t;
    typedef logic [NUM_CH-1:0] chan_vec_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } lfsr_act_t;
endpackage

// File: rtl/pattern_lfsr.sv
module pattern_lfsr
    import lfsr_ps_pkg::*;
#(
    parameter lfsr_state_t DEFAULT_SEED = lfsr_state_t'(1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        load,
    input  lfsr_state_t seed,
    output lfsr_state_t state
);
    lfsr_act_t   act;
    lfsr_state_t state_q;
    lfsr_state_t state_d;
    lfsr_state_t safe_seed;
    logic        feedback;

    // Action selector: load wins over step
    always_comb begin
        if (load) begin
            act = ACT_LOAD;
        end else if (en) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

    assign safe_seed = (seed == '0) ? DEFAULT_SEED : seed;
    // x^4 + x + 1: new top stage from the two lowest stages
    assign feedback  = state_q[0] ^ state_q[1];

    always_comb begin
        state_d = state_q;
        unique case (act)
            ACT_LOAD: state_d = safe_seed;
            ACT_STEP: state_d = {feedback, state_q[LFSR_W-1:1]};
            ACT_HOLD: state_d = state_q;
            default:  state_d = DEFAULT_SEED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DEFAULT_SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/xor_phase_shifter.sv
module xor_phase_shifter
    import lfsr_ps_pkg::*;
(
    input  lfsr_state_t state,
    output chan_vec_t   chan
);
    logic x1, x2, x3, x4;
    logic lead4, lead6;

    assign x1 = state[0];
    assign x2 = state[1];
    assign x3 = state[2];
    assign x4 = state[3];

    // Four two-input XORs; lead4 and lead6 are reused
    assign lead6 = x3 ^ x4;
    assign lead4 = x1 ^ x2;

    assign chan[0] = x1;
    assign chan[1] = lead6;
    assign chan[2] = lead4;
    assign chan[3] = lead6 ^ lead4;
    assign chan[4] = lead4 ^ x4;
endmodule

// File: rtl/lfsr_phase_tpg.sv
module lfsr_phase_tpg
    import lfsr_ps_pkg::*;
#(
    parameter logic [3:0] DEFAULT_SEED = 4'b0001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       load,
    input  logic [3:0] seed,
    output logic [4:0] chan,
    output logic [3:0] state
);
    lfsr_state_t lfsr_q;
    chan_vec_t   chan_w;

    pattern_lfsr #(
        .DEFAULT_SEED (lfsr_state_t'(DEFAULT_SEED))
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .load  (load),
        .seed  (lfsr_state_t'(seed)),
        .state (lfsr_q)
    );

    xor_phase_shifter u_shift (
        .state (lfsr_q),
        .chan  (chan_w)
    );

    assign chan  = chan_w;
    assign state = lfsr_q;
endmodule

// File: rtl/lfsr_phase_tpg_chk.sv
module lfsr_phase_tpg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       load,
    input logic [3:0] seed,
    input logic [4:0] chan,
    input logic [3:0] state
);
    // Number of consecutive stepping edges, saturating at 7
    logic [2:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 3'd0;
        end else if (en && !load) begin
            run <= (run == 3'd7) ? run : run + 3'd1;
        end else begin
            run <= 3'd0;
        end
    end

    AST_STEP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load) |=> (state[2:0] == $past(state[3:1]))); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> ($stable(state) && $stable(chan))); // R3
    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed != 4'd0) |=> (state == $past(seed))); // R4
    AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed == 4'd0) |=> (state == 4'b0001)); // R4
    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state != 4'd0); // R5
    AST_CH3_LEAD4: assert property (@(posedge clk) disable iff (!rst_n)
        (run >= 3'd4) |-> (chan[0] == $past(chan[2], 4))); // R8
    AST_CH2_LEAD6: assert property (@(posedge clk) disable iff (!rst_n)
        (run >= 3'd2) |-> (chan[2] == $past(chan[1], 2))); // R9
    AST_CH4_LEAD12: assert property (@(posedge clk) disable iff (!rst_n)
        (run >= 3'd5) |-> (chan[4] == $past(chan[3], 5))); // R10
    AST_CH5_LEAD7: assert property (@(posedge clk) disable iff (!rst_n)
        (run >= 3'd3) |-> (chan[2] == $past(chan[4], 3))); // R11
endmodule

bind lfsr_phase_tpg lfsr_phase_tpg_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .load  (load),
    .seed  (seed),
    .chan  (chan),
    .state (state)
);

// File: tb/lfsr_phase_tpg_tb.sv
`timescale 1ns/100ps
module lfsr_phase_tpg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       load = 1'b0;
    logic [3:0] seed = 4'd0;
    logic [4:0] chan;
    logic [3:0] state;

    int checks = 0;
    int fails = 0;
    bit seq[$];
    int    lead [5] = '{0, 6, 4, 12, 7};
    string ctag [5] = '{"R7", "R9", "R8", "R10", "R11"};

    always #2.5 clk = ~clk;

    lfsr_phase_tpg u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .load  (load),
        .seed  (seed),
        .chan  (chan),
        .state (state)
    );

    // Reference: the x1 bit stream seen from the present step onward
    task automatic extend();
        while (seq.size() < 20) begin
            seq.push_back(seq[seq.size()-4] ^ seq[seq.size()-3]);
        end
    endtask

    task automatic fill_from(input logic [3:0] s);
        seq.delete();
        for (int i = 0; i < 4; i++) seq.push_back(s[i]);
        extend();
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare(input string sreq);
        int exp_state;
        exp_state = {28'd0, seq[3], seq[2], seq[1], seq[0]};
        check(sreq, int'(state), exp_state);
        check("R5", int'(state != 4'd0), 1);
        for (int k = 0; k < 5; k++) begin
            check(ctag[k], int'(chan[k]), int'(seq[lead[k]]));
        end
    endtask

    task automatic step(input bit e, input bit l, input logic [3:0] sd, input string req);
        @(negedge clk);
        en = e;
        load = l;
        seed = sd;
        @(posedge clk);
        #1;
        if (l) begin
            fill_from((sd == 4'd0) ? 4'b0001 : sd);
        end else if (e) begin
            void'(seq.pop_front());
            extend();
        end
        compare(req);
    endtask

    initial begin
        bit seen [16];
        int distinct;
        fill_from(4'b0001);
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;

        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 4'd0, "R2");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4'd0, "R3");
        for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 4'd0, "R2");

        step(1'b0, 1'b1, 4'b1010, "R4");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 4'd0, "R3");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 4'd0, "R2");
        step(1'b1, 1'b1, 4'b0110, "R4");
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 4'd0, "R2");
        step(1'b1, 1'b1, 4'b0000, "R4");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 4'd0, "R2");

        step(1'b0, 1'b1, 4'b1011, "R4");
        for (int i = 0; i < 16; i++) seen[i] = 1'b0;
        distinct = 0;
        for (int i = 0; i < 15; i++) begin
            step(1'b1, 1'b0, 4'd0, "R2");
            if (!seen[state]) distinct++;
            seen[state] = 1'b1;
        end
        check("R6", int'(state), 11);
        check("R6", distinct, 15);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule